// File: doc/BRIEF.md
# Reload Baud and Clock-Out Generator

This block is the serial-rate mode of a 16-bit reload timer. It runs from the oscillator clock, and its counter advances once per state time, which is every second oscillator clock. When the counter rolls over from all ones, it reloads from a 16-bit reload value. One rollover period is therefore N = 65536 − reload state times, or 2N oscillator clocks.

A 4-bit prescaler counts rollovers. Every sixteenth rollover it produces a baud tick, so the tick period is 32N oscillator clocks. The tick is gated separately for the transmit direction and the receive direction. The same rollovers can also toggle a clock-out pin. That pin has 50% duty and a period of 4N oscillator clocks. Baud generation and clock-out may be used together, but they share the one reload value.

A falling edge on the external trigger input only sets a flag. It never forces a reload. Rollovers in this mode raise no overflow flag and no interrupt. The block has no streaming data path, so all pins are plain control and status signals.

Top module: `brg_top`

## Requirements
- R1: After reset, `tx_tick`, `rx_tick`, `clk_out` and `ext_flag` are all 0.
- R2: With `run`=1 and `tx_sel`=1, the first `tx_tick` comes 32N clock edges after the first edge at which the mode is active. After that, `tx_tick` repeats every 32N edges, where N = 65536 − `reload`. Each tick is one clock wide.
- R3: With `run`, `timer_sel` and `clkout_en` all 1, `clk_out` first toggles 2N edges after activation. It then toggles every 2N edges.
- R4: While `timer_sel`=0 or `clkout_en`=0, `clk_out` never changes.
- R5: While `run`=0, `clk_out` holds its level, no tick is produced, and the counter is loaded with `reload`.
- R6: `tx_tick` pulses only when `tx_sel`=1, and `rx_tick` pulses only when `rx_sel`=1. When both selects are 1, the two ticks pulse in the same cycles.
- R7: With `trig_en`=1, a falling edge of `trig_in` sets `ext_flag` at the edge after `trig_in` is first sampled low. With `trig_en`=0 the flag is not set. A trigger never changes the tick timing.
- R8: A `flag_clr` pulse clears `ext_flag`. If a trigger edge arrives in the same cycle, the set wins.
- R9: Counter rollovers never set `ext_flag`.
- R10: The prescaler is cleared while neither `tx_sel` nor `rx_sel` is 1. After re-entering the mode from a reloaded counter, the next tick therefore again takes 32N edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Run bit; when low, the counter is held at `reload` |
| tx_sel | input | 1 | Use the rollovers for transmit clocking |
| rx_sel | input | 1 | Use the rollovers for receive clocking |
| timer_sel | input | 1 | Timer function selected; required for clock-out |
| clkout_en | input | 1 | Clock-out enable |
| trig_in | input | 1 | External trigger input |
| trig_en | input | 1 | Enables the trigger to set the flag |
| flag_clr | input | 1 | Clears `ext_flag` |
| reload | input | 16 | Reload value |
| tx_tick | output | 1 | Transmit baud tick, one clock wide |
| rx_tick | output | 1 | Receive baud tick, one clock wide |
| clk_out | output | 1 | 50% duty clock output |
| ext_flag | output | 1 | External trigger flag |

## Verification
The bench sweeps N from 1 to 16 and measures both the first-tick latency and the repeat interval. A design with an off-by-one at the rollover, one that counts every clock instead of every state time, or one with a wrong prescaler width would miss 32N. Clock-out half-periods are checked against 2N, and the pin is watched for any movement while it is gated off or while `run` is low.

Three trigger checks are made. A trigger in the middle of a period must leave the tick timing untouched; a design that reloads on the trigger would shift it. A disabled trigger must leave the flag clear. Long runs full of rollovers must never set the flag.

The bench also leaves the mode partway through a prescaler count and re-enters it. A prescaler that is not cleared would give a shortened first tick.

// File: rtl/brg_pkg.sv
package brg_pkg;
  localparam int CNT_W = 16;
  localparam int PRE_W = 4;
  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/brg_state_pace.sv
module brg_state_pace (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic step
);
  logic phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= 1'b0;
    else if (!active) phase <= 1'b0;
    else              phase <= ~phase;
  end

  assign step = active & phase;
endmodule

// File: rtl/brg_reload_ctr.sv
module brg_reload_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         step,
  input  logic [W-1:0] reload,
  output logic         roll
);
  localparam logic [W-1:0] TOP = '1;
  logic [W-1:0] count;

  assign roll = step & (count == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (!run) count <= reload;
    else if (roll) count <= reload;
    else if (step) count <= count + 1'b1;
  end
endmodule

// File: rtl/brg_baud_presc.sv
module brg_baud_presc #(
  parameter int PW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_sel,
  input  logic rx_sel,
  input  logic roll,
  output logic tx_tick,
  output logic rx_tick
);
  localparam logic [PW-1:0] LAST = '1;
  logic [PW-1:0] pre;
  logic          baud_mode;
  logic          wrap;

  assign baud_mode = tx_sel | rx_sel;
  assign wrap      = baud_mode & roll & (pre == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre     <= '0;
      tx_tick <= 1'b0;
      rx_tick <= 1'b0;
    end else begin
      if (!baud_mode) pre <= '0;
      else if (roll)  pre <= pre + 1'b1;
      tx_tick <= wrap & tx_sel;
      rx_tick <= wrap & rx_sel;
    end
  end
endmodule

// File: rtl/brg_trig_flag.sv
module brg_trig_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  input  logic trig_en,
  input  logic flag_clr,
  output logic flag
);
  logic trig_q;
  logic fall;

  assign fall = trig_en & trig_q & ~trig_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      flag   <= 1'b0;
    end else begin
      trig_q <= trig_in;
      if (fall)          flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/brg_top.sv
module brg_top
  import brg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       tx_sel,
  input  logic       rx_sel,
  input  logic       timer_sel,
  input  logic       clkout_en,
  input  logic       trig_in,
  input  logic       trig_en,
  input  logic       flag_clr,
  input  logic [15:0] reload,
  output logic       tx_tick,
  output logic       rx_tick,
  output logic       clk_out,
  output logic       ext_flag
);
  logic clk_gate;
  logic active;
  logic step;
  logic roll;

  assign clk_gate = timer_sel & clkout_en;
  assign active   = run & (tx_sel | rx_sel | clk_gate);

  brg_state_pace u_pace (
    .clk(clk), .rst_n(rst_n), .active(active), .step(step)
  );

  brg_reload_ctr #(.W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .run(run), .step(step),
    .reload(cnt_t'(reload)), .roll(roll)
  );

  brg_baud_presc #(.PW(PRE_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .tx_sel(tx_sel), .rx_sel(rx_sel),
    .roll(roll), .tx_tick(tx_tick), .rx_tick(rx_tick)
  );

  brg_trig_flag u_trig (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_en(trig_en),
    .flag_clr(flag_clr), .flag(ext_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                clk_out <= 1'b0;
    else if (clk_gate && roll) clk_out <= ~clk_out;
  end
endmodule

// File: rtl/brg_checker.sv
module brg_checker (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic tx_sel,
  input logic rx_sel,
  input logic timer_sel,
  input logic clkout_en,
  input logic trig_in,
  input logic trig_en,
  input logic tx_tick,
  input logic rx_tick,
  input logic clk_out,
  input logic ext_flag
);
  AST_TX_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tick |-> $past(tx_sel));                                   // R6
  AST_RX_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_tick |-> $past(rx_sel));                                   // R6
  AST_TICK_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tick |=> !tx_tick);                                        // R2
  AST_CLKOUT_HOLD_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> $stable(clk_out));                            // R5
  AST_CLKOUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(timer_sel) || !$past(clkout_en)) |-> $stable(clk_out)); // R4
  AST_FLAG_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_flag) |-> ($past(trig_en) && !$past(trig_in) && $past(trig_in, 2))); // R7
  AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> !tx_tick && !rx_tick);                        // R5
endmodule

bind brg_top brg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .tx_sel(tx_sel), .rx_sel(rx_sel),
  .timer_sel(timer_sel), .clkout_en(clkout_en), .trig_in(trig_in),
  .trig_en(trig_en), .tx_tick(tx_tick), .rx_tick(rx_tick),
  .clk_out(clk_out), .ext_flag(ext_flag)
);

// File: tb/tb_brg_top.sv
`timescale 1ns/1ps
module tb_brg_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 0, tx_sel = 0, rx_sel = 0, timer_sel = 0, clkout_en = 0;
  logic trig_in = 0, trig_en = 0, flag_clr = 0;
  logic [15:0] reload = 16'hFFFF;
  logic tx_tick, rx_tick, clk_out, ext_flag;
  int nchk = 0, nerr = 0, txc = 0, rxc = 0, both = 0;

  always #4 clk = ~clk;

  brg_top dut (
    .clk(clk), .rst_n(rst_n), .run(run), .tx_sel(tx_sel), .rx_sel(rx_sel),
    .timer_sel(timer_sel), .clkout_en(clkout_en), .trig_in(trig_in),
    .trig_en(trig_en), .flag_clr(flag_clr), .reload(reload),
    .tx_tick(tx_tick), .rx_tick(rx_tick), .clk_out(clk_out), .ext_flag(ext_flag)
  );

  always @(negedge clk) begin
    if (tx_tick === 1'b1) txc++;
    if (rx_tick === 1'b1) rxc++;
    if (tx_tick === 1'b1 && rx_tick === 1'b1) both++;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    #1;
  endtask

  task automatic wait_tick(input bit use_rx, input int lim, output int n);
    n = 0;
    for (int k = 1; k <= lim; k++) begin
      @(posedge clk); #1;
      if ((use_rx ? rx_tick : tx_tick) === 1'b1) begin n = k; break; end
    end
  endtask

  task automatic wait_toggle(input int lim, output int n);
    logic old;
    old = clk_out;
    n = 0;
    for (int k = 1; k <= lim; k++) begin
      @(posedge clk); #1;
      if (clk_out !== old) begin n = k; break; end
    end
  endtask

  task automatic park(input int nval);
    @(negedge clk);
    run = 0; tx_sel = 0; rx_sel = 0; clkout_en = 0; timer_sel = 0;
    reload = 16'(65536 - nval);
    edges(2);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int n, t0, r0;
    logic lvl;
    edges(3);
    chk("R1 tx_tick", tx_tick, 0);
    chk("R1 rx_tick", rx_tick, 0);
    chk("R1 clk_out", clk_out, 0);
    chk("R1 ext_flag", ext_flag, 0);
    @(negedge clk) rst_n = 1;

    // R2: latency and interval sweep over N
    for (int nv = 1; nv <= 16; nv++) begin
      park(nv);
      run = 1; tx_sel = 1;
      wait_tick(0, 40 * nv, n);
      chk("R2 first tick", n, 32 * nv);
      wait_tick(0, 40 * nv, n);
      chk("R2 interval", n, 32 * nv);
    end

    // R3/R5: clock-out
    for (int nv = 1; nv <= 8; nv++) begin
      park(nv);
      timer_sel = 1; clkout_en = 1; run = 1;
      wait_toggle(4 * nv, n);
      chk("R3 first toggle", n, 2 * nv);
      wait_toggle(4 * nv, n);
      chk("R3 half period", n, 2 * nv);
      @(negedge clk) run = 0;
      lvl = clk_out;
      t0 = txc;
      edges(10 * nv + 5);
      chk("R5 clk_out held", clk_out, lvl);
      chk("R5 no tick stopped", txc - t0, 0);
    end

    // R4: clock-out gated
    park(2);
    clkout_en = 1; timer_sel = 0; tx_sel = 1; run = 1;
    lvl = clk_out;
    edges(200);
    chk("R4 timer_sel=0 holds", clk_out, lvl);
    park(2);
    clkout_en = 0; timer_sel = 1; tx_sel = 1; run = 1;
    lvl = clk_out;
    edges(200);
    chk("R4 clkout_en=0 holds", clk_out, lvl);

    // R6: per-direction gating
    park(2);
    rx_sel = 1; run = 1;
    t0 = txc;
    wait_tick(1, 100, n);
    chk("R6 rx first tick", n, 64);
    chk("R6 no tx tick", txc - t0, 0);
    park(2);
    tx_sel = 1; rx_sel = 1; run = 1;
    t0 = txc; r0 = rxc; n = both;
    edges(64 * 5 + 2);
    chk("R6 tx count both", txc - t0, 5);
    chk("R6 rx count both", rxc - r0, 5);
    chk("R6 coincident", both - n, 5);

    // R7/R8: trigger flag, no reload
    park(4);
    trig_en = 0; trig_in = 1;
    edges(3);
    @(negedge clk) trig_in = 0;
    edges(3);
    chk("R7 disabled no flag", ext_flag, 0);
    park(4);
    trig_en = 1; trig_in = 1; tx_sel = 1; run = 1;
    n = 0;
    for (int k = 1; k <= 200; k++) begin
      if (k == 40) trig_in = 0;
      @(posedge clk); #1;
      if (k == 41) chk("R7 flag set", ext_flag, 1);
      if (tx_tick === 1'b1 && n == 0) n = k;
      @(negedge clk);
    end
    chk("R7 no reload on trigger", n, 128);
    flag_clr = 1;
    edges(1);
    @(negedge clk) flag_clr = 0;
    chk("R8 flag cleared", ext_flag, 0);
    trig_in = 1;
    edges(2);
    @(negedge clk) begin trig_in = 0; flag_clr = 1; end
    edges(1);
    @(negedge clk) flag_clr = 0;
    chk("R8 set wins over clear", ext_flag, 1);
    @(negedge clk) flag_clr = 1;
    edges(1);
    @(negedge clk) flag_clr = 0;

    // R9: rollovers leave the flag alone
    park(1);
    trig_en = 1; trig_in = 1; tx_sel = 1; timer_sel = 1; clkout_en = 1; run = 1;
    edges(500);
    chk("R9 no flag from rollovers", ext_flag, 0);

    // R10: prescaler cleared on mode exit
    park(3);
    tx_sel = 1; run = 1;
    edges(50);
    @(negedge clk) begin run = 0; tx_sel = 0; end
    edges(2);
    @(negedge clk) begin run = 1; tx_sel = 1; end
    wait_tick(0, 200, n);
    chk("R10 fresh latency", n, 96);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule